// File: doc/BRIEF.md
# Circular Register-File Hardware Stack

This block is a last-in-first-out operand store. It keeps its entries in a ring of word registers and walks the ring with two wrapping indices. The head index points at the current top entry. The boundary index marks the slot just below the oldest live entry. Each cycle the block takes one command with a data word. The command may do nothing, push the word, pop the top, or overwrite the top. The block always presents the top word and the word below it. A second instance of the same block can hold return addresses.

Sixteen entries fill the ring. When the ring is full and another push arrives, the oldest entry is lost, and an overflow pulse is raised. What happens to the lost entry depends on the spill mode. With spilling off, the old contents are dropped and only the new word stays visible. With spilling on, the oldest entry is evicted to an external memory through a request/acknowledge handshake. A pop on an empty stack raises an underflow pulse. With spilling on, that pop instead fetches one word back from memory and makes it the new top. While a transfer is in flight the block reports busy and accepts no commands.

Top module: `circ_stack`

## Requirements
- R1: After reset the stack is empty (`empty`=1, `full`=0), and `overflow`, `underflow`, `busy` and `mem_req` are all 0.
- R2: A push (`cmd`=01) of word W shows W on `top_data` after the next rising edge, with the former top word on `next_data`. Pops return words in the reverse order of their pushes.
- R3: A pop (`cmd`=10) on a non-empty stack removes the top entry. Popping the last entry sets `empty`.
- R4: A replace-top (`cmd`=11) on a non-empty stack writes the data word over the top entry. It leaves `next_data` and the depth unchanged.
- R5: `full` rises exactly when the sixteenth live entry is pushed, and not after the fifteenth.
- R6: With `spill_en`=0, a push onto a full stack pulses `overflow` for one cycle. Afterwards the stack holds only the new word, so a single pop empties it.
- R7: With `spill_en`=0, a pop or replace-top on an empty stack pulses `underflow` for one cycle. It changes nothing, and the stack stays empty.
- R8: With `spill_en`=1, a push onto a full stack pulses `overflow` and raises `mem_req` and `busy` with `mem_write`=1. `mem_wdata` carries the oldest entry. The stack stays full with the new word on top.
- R9: With `spill_en`=1, a pop on an empty stack pulses `underflow` and raises `mem_req` with `mem_write`=0. It does not itself pop. At the completing edge, `mem_rdata` becomes the only entry and shows on `top_data`.
- R10: While a request is outstanding, `mem_req`, `mem_write` and `mem_wdata` hold, and every command is ignored. The request ends at the first rising edge where `mem_ack`=1 and `stall`=0.
- R11: While `stall`=1, no command takes effect and no transfer completes.
- R12: A no-op command (`cmd`=00) leaves the stack contents, `top_data` and `next_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stall | input | 1 | Freezes command acceptance and transfer completion |
| spill_en | input | 1 | Selects evict/refill over discard on overflow and underflow |
| cmd | input | 2 | 00 none, 01 push, 10 pop, 11 replace top |
| din | input | 16 | Word for push or replace |
| top_data | output | 16 | Current top entry |
| next_data | output | 16 | Entry below the top |
| empty | output | 1 | No live entries |
| full | output | 1 | Sixteen live entries |
| overflow | output | 1 | One-cycle pulse after a push onto a full stack |
| underflow | output | 1 | One-cycle pulse after a pop or replace on an empty stack |
| busy | output | 1 | Memory transfer outstanding, commands ignored |
| mem_req | output | 1 | Transfer request, held until completion |
| mem_write | output | 1 | 1 evict (write to memory), 0 refill (read) |
| mem_wdata | output | 16 | Evicted word |
| mem_ack | input | 1 | Memory acknowledge, held until `mem_req` falls |
| mem_rdata | input | 16 | Refill word, valid with `mem_ack` |

## Verification
The embedded properties rely on two rules for the memory side. The memory raises `mem_ack` only while `mem_req` is high. It holds `mem_ack` and `mem_rdata` steady until the request drops, since a stall can postpone completion. The properties also assume `cmd` is sampled only at rising edges, so a command placed during a stall or a busy cycle is simply dropped. The bench changes its inputs only on falling edges. It raises the acknowledge only after it has seen a request, and releases it once the request has fallen.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_PUSH = 2'b01,
    CMD_POP  = 2'b10,
    CMD_REPL = 2'b11
  } stk_cmd_e;
endpackage

// File: rtl/stk_ring_regs.sv
module stk_ring_regs #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_idx_a,
  output logic [WIDTH-1:0] rd_data_a,
  input  logic [AW-1:0]    rd_idx_b,
  output logic [WIDTH-1:0] rd_data_b,
  input  logic [AW-1:0]    rd_idx_c,
  output logic [WIDTH-1:0] rd_data_c
);
  logic [DEPTH-1:0][WIDTH-1:0] slot_bus;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic             slot_en;
    logic [WIDTH-1:0] slot_q;
    assign slot_en = wr_en && (wr_idx == AW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= wr_data;
    end
    assign slot_bus[g] = slot_q;
  end

  assign rd_data_a = slot_bus[rd_idx_a];
  assign rd_data_b = slot_bus[rd_idx_b];
  assign rd_data_c = slot_bus[rd_idx_c];
endmodule

// File: rtl/stk_spill_port.sv
module stk_spill_port #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             start_evict,
  input  logic             start_refill,
  input  logic [WIDTH-1:0] evict_data,
  input  logic             mem_ack,
  input  logic [WIDTH-1:0] mem_rdata,
  output logic             mem_req,
  output logic             mem_write,
  output logic [WIDTH-1:0] mem_wdata,
  output logic             fill_valid,
  output logic [WIDTH-1:0] fill_data
);
  logic             req_q, req_d;
  logic             wr_q, wr_d;
  logic [WIDTH-1:0] wdata_q;
  logic             done;
  logic             dir_en;

  assign done   = req_q && mem_ack && !stall;
  assign dir_en = start_evict || start_refill;

  always_comb begin
    req_d = req_q;
    wr_d  = wr_q;
    if (start_evict) begin
      req_d = 1'b1;
      wr_d  = 1'b1;
    end else if (start_refill) begin
      req_d = 1'b1;
      wr_d  = 1'b0;
    end else if (done) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      if (dir_en) wr_q <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (start_evict) begin
      wdata_q <= evict_data;
    end
  end

  assign mem_req    = req_q;
  assign mem_write  = wr_q;
  assign mem_wdata  = wdata_q;
  assign fill_valid = done && !wr_q;
  assign fill_data  = mem_rdata;

  // R10: an open request and its payload hold until an unstalled acknowledge
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !(mem_ack && !stall)) |=> (req_q && $stable(wr_q) && $stable(wdata_q)));

  // R10: the index controller never opens a transfer while one is pending
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evict || start_refill) |-> !req_q);
endmodule

// File: rtl/stk_index_ctrl.sv
module stk_index_ctrl
  import stk_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          busy,
  input  logic          spill_en,
  input  logic [1:0]    cmd,
  input  logic          fill_valid,
  output logic [AW-1:0] top_idx,
  output logic [AW-1:0] evict_idx,
  output logic          empty,
  output logic          full,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic          start_evict,
  output logic          start_refill,
  output logic          ovf_pulse,
  output logic          udf_pulse
);
  logic [AW-1:0] top_q, top_d;
  logic [AW-1:0] bnd_q, bnd_d;
  logic          empty_q, empty_d;
  logic          ovf_q, ovf_d;
  logic          udf_q, udf_d;
  logic [AW-1:0] top_inc, top_dec;
  logic          accept;
  logic          state_en;
  logic          full_w;

  assign accept   = !stall && !busy;
  assign state_en = accept || fill_valid;
  assign top_inc  = top_q + 1'b1;
  assign top_dec  = top_q - 1'b1;
  assign full_w   = !empty_q && (top_q == bnd_q);

  always_comb begin
    top_d        = top_q;
    bnd_d        = bnd_q;
    empty_d      = empty_q;
    ovf_d        = 1'b0;
    udf_d        = 1'b0;
    wr_en        = 1'b0;
    wr_idx       = top_q;
    start_evict  = 1'b0;
    start_refill = 1'b0;
    if (fill_valid) begin
      wr_en   = 1'b1;
      bnd_d   = top_dec;
      empty_d = 1'b0;
    end else if (accept) begin
      case (cmd)
        CMD_PUSH: begin
          wr_en   = 1'b1;
          wr_idx  = top_inc;
          top_d   = top_inc;
          empty_d = 1'b0;
          if (full_w) begin
            ovf_d = 1'b1;
            if (spill_en) begin
              bnd_d       = top_inc;
              start_evict = 1'b1;
            end else begin
              bnd_d = top_q;
            end
          end
        end
        CMD_POP: begin
          if (empty_q) begin
            udf_d        = 1'b1;
            start_refill = spill_en;
          end else begin
            top_d = top_dec;
            if (top_dec == bnd_q) empty_d = 1'b1;
          end
        end
        CMD_REPL: begin
          if (empty_q) udf_d = 1'b1;
          else         wr_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q   <= '0;
      bnd_q   <= '0;
      empty_q <= 1'b1;
    end else if (state_en) begin
      top_q   <= top_d;
      bnd_q   <= bnd_d;
      empty_q <= empty_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  assign top_idx   = top_q;
  assign evict_idx = top_inc;
  assign empty     = empty_q;
  assign full      = full_w;
  assign ovf_pulse = ovf_q;
  assign udf_pulse = udf_q;

  // R6: a discarding overflow leaves exactly one live entry
  assert_ovf_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !$past(spill_en)) |-> (!empty_q && (top_q == AW'(bnd_q + 1'b1))));

  // R7: an underflow pulse is only ever seen with the stack still empty
  assert_udf_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    udf_q |-> empty_q);

  // R11: a stalled cycle changes no index and no empty mark
  assert_stall_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(top_q) && $stable(bnd_q) && $stable(empty_q)));

  // R10: a pending transfer freezes the stack until its data lands
  assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fill_valid) |=> ($stable(top_q) && $stable(bnd_q) && $stable(empty_q)));
endmodule

// File: rtl/circ_stack.sv
module circ_stack #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             spill_en,
  input  logic [1:0]       cmd,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] top_data,
  output logic [WIDTH-1:0] next_data,
  output logic             empty,
  output logic             full,
  output logic             overflow,
  output logic             underflow,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_write,
  output logic [WIDTH-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [WIDTH-1:0] mem_rdata
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [AW-1:0]    top_idx, evict_idx, wr_idx, next_idx;
  logic             wr_en;
  logic [WIDTH-1:0] wr_data, evict_data, fill_data;
  logic             fill_valid, start_evict, start_refill;
  logic             req_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  stk_index_ctrl #(.AW(AW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .stall        (stall),
    .busy         (req_w),
    .spill_en     (spill_en),
    .cmd          (cmd),
    .fill_valid   (fill_valid),
    .top_idx      (top_idx),
    .evict_idx    (evict_idx),
    .empty        (empty),
    .full         (full),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .start_evict  (start_evict),
    .start_refill (start_refill),
    .ovf_pulse    (overflow),
    .udf_pulse    (underflow)
  );

  assign next_idx = top_idx - 1'b1;
  assign wr_data  = fill_valid ? fill_data : din;

  stk_ring_regs #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx_a  (top_idx),
    .rd_data_a (top_data),
    .rd_idx_b  (next_idx),
    .rd_data_b (next_data),
    .rd_idx_c  (evict_idx),
    .rd_data_c (evict_data)
  );

  stk_spill_port #(.WIDTH(WIDTH)) u_spill (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .stall        (stall),
    .start_evict  (start_evict),
    .start_refill (start_refill),
    .evict_data   (evict_data),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .mem_req      (req_w),
    .mem_write    (mem_write),
    .mem_wdata    (mem_wdata),
    .fill_valid   (fill_valid),
    .fill_data    (fill_data)
  );

  assign mem_req = req_w;
  assign busy    = req_w;
endmodule

// File: tb/circ_stack_bench.sv
module circ_stack_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall, spill_en, mem_ack;
  logic [1:0]  cmd;
  logic [15:0] din, mem_rdata;
  logic [15:0] top_data, next_data, mem_wdata;
  logic        empty, full, overflow, underflow, busy, mem_req, mem_write;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  circ_stack u_circ_stack (
    .clk(clk), .rst_n(rst_n), .stall(stall), .spill_en(spill_en),
    .cmd(cmd), .din(din), .top_data(top_data), .next_data(next_data),
    .empty(empty), .full(full), .overflow(overflow), .underflow(underflow),
    .busy(busy), .mem_req(mem_req), .mem_write(mem_write), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // fields: cmd[58:57] din[56:41] chk_top[40] top[39:24] chk_next[23]
  //         next[22:7] empty[6] underflow[5] overflow[4] req[3:0]
  localparam int NV = 10;
  localparam logic [58:0] VEC [NV] = '{
    {2'b01, 16'hA1A1, 1'b1, 16'hA1A1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    {2'b01, 16'hB2B2, 1'b1, 16'hB2B2, 1'b1, 16'hA1A1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    {2'b11, 16'hC3C3, 1'b1, 16'hC3C3, 1'b1, 16'hA1A1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    {2'b00, 16'h5A5A, 1'b1, 16'hC3C3, 1'b1, 16'hA1A1, 1'b0, 1'b0, 1'b0, 4'd12}, // R12
    {2'b10, 16'h0000, 1'b1, 16'hA1A1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
    {2'b10, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
    {2'b10, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 4'd7},  // R7
    {2'b11, 16'h5555, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 4'd7},  // R7
    {2'b01, 16'hD4D4, 1'b1, 16'hD4D4, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    {2'b10, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd3}   // R3
  };

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // drive a command for one rising edge; returns at the following falling edge
  task automatic apply(input logic [1:0] c, input logic [15:0] d);
    cmd = c;
    din = d;
    @(negedge clk);
    cmd = 2'b00;
    din = 16'h0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; stall = 1'b0; spill_en = 1'b0; mem_ack = 1'b0;
    cmd = 2'b00; din = 16'h0; mem_rdata = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", "empty", 16'(empty), 16'd1);
    chk("R1", "full", 16'(full), 16'd0);
    chk("R1", "overflow", 16'(overflow), 16'd0);
    chk("R1", "underflow", 16'(underflow), 16'd0);
    chk("R1", "busy", 16'(busy), 16'd0);
    chk("R1", "mem_req", 16'(mem_req), 16'd0);

    // vector table, spill disabled
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i][3:0]);
      apply(VEC[i][58:57], VEC[i][56:41]);
      if (VEC[i][40]) chk(tag, "top_data", top_data, VEC[i][39:24]);
      if (VEC[i][23]) chk(tag, "next_data", next_data, VEC[i][22:7]);
      chk(tag, "empty", 16'(empty), 16'(VEC[i][6]));
      chk(tag, "underflow", 16'(underflow), 16'(VEC[i][5]));
      chk(tag, "overflow", 16'(overflow), 16'(VEC[i][4]));
    end

    // R5: fill to sixteen entries
    for (int i = 0; i < 16; i++) begin
      apply(2'b01, 16'h0100 + 16'(i));
      if (i == 14) chk("R5", "full after 15", 16'(full), 16'd0);
    end
    chk("R5", "full after 16", 16'(full), 16'd1);
    chk("R5", "top_data", top_data, 16'h010F);
    chk("R5", "next_data", next_data, 16'h010E);

    // R6: overflow discards the old contents
    apply(2'b01, 16'hBEEF);
    chk("R6", "overflow pulse", 16'(overflow), 16'd1);
    chk("R6", "top_data", top_data, 16'hBEEF);
    chk("R6", "full", 16'(full), 16'd0);
    chk("R6", "mem_req", 16'(mem_req), 16'd0);
    apply(2'b00, 16'h0);
    chk("R6", "overflow cleared", 16'(overflow), 16'd0);
    apply(2'b10, 16'h0);
    chk("R6", "single entry", 16'(empty), 16'd1);

    // R11: stalled push has no effect
    stall = 1'b1;
    apply(2'b01, 16'h3333);
    stall = 1'b0;
    chk("R11", "empty under stall", 16'(empty), 16'd1);

    // R8: overflow with eviction
    spill_en = 1'b1;
    for (int i = 0; i < 16; i++) apply(2'b01, 16'h0200 + 16'(i));
    apply(2'b01, 16'hCAFE);
    chk("R8", "overflow pulse", 16'(overflow), 16'd1);
    chk("R8", "mem_req", 16'(mem_req), 16'd1);
    chk("R8", "busy", 16'(busy), 16'd1);
    chk("R8", "mem_write", 16'(mem_write), 16'd1);
    chk("R8", "mem_wdata oldest", mem_wdata, 16'h0200);
    chk("R8", "full kept", 16'(full), 16'd1);
    chk("R8", "top_data", top_data, 16'hCAFE);

    // R10: commands ignored while busy
    apply(2'b01, 16'h1111);
    chk("R10", "top_data unchanged", top_data, 16'hCAFE);
    chk("R10", "next_data unchanged", next_data, 16'h020F);
    chk("R10", "mem_wdata held", mem_wdata, 16'h0200);

    // R11/R10: acknowledge under stall does not complete
    stall = 1'b1; mem_ack = 1'b1;
    @(negedge clk);
    chk("R11", "req held under stall", 16'(mem_req), 16'd1);
    stall = 1'b0;
    @(negedge clk);
    chk("R10", "req released", 16'(mem_req), 16'd0);
    mem_ack = 1'b0;

    // R2/R3: drain in reverse order
    for (int i = 0; i < 16; i++) begin
      logic [15:0] exp;
      exp = (i == 0) ? 16'hCAFE : 16'h020F - 16'(i - 1);
      chk("R2", "lifo order", top_data, exp);
      apply(2'b10, 16'h0);
    end
    chk("R3", "empty after drain", 16'(empty), 16'd1);

    // R9: underflow with refill
    apply(2'b10, 16'h0);
    chk("R9", "underflow pulse", 16'(underflow), 16'd1);
    chk("R9", "mem_req", 16'(mem_req), 16'd1);
    chk("R9", "mem_write", 16'(mem_write), 16'd0);
    chk("R9", "still empty", 16'(empty), 16'd1);
    mem_ack = 1'b1; mem_rdata = 16'h7777;
    @(negedge clk);
    mem_ack = 1'b0;
    chk("R9", "req done", 16'(mem_req), 16'd0);
    chk("R9", "refilled", 16'(empty), 16'd0);
    chk("R9", "top_data", top_data, 16'h7777);
    apply(2'b10, 16'h0);
    chk("R9", "one entry", 16'(empty), 16'd1);

    finish_run();
  end
endmodule